// File: doc/BRIEF.md
# Broadcast-Controlled Masked Element Array

This block is a small array of processing elements (PEs). Each PE holds one 32-bit data word and one enable flag. A single central sequencer steps through a fixed program ROM and hands the same instruction to every PE in the same cycle. The PEs never fetch or decode a program of their own. Conditional work is expressed through the flags. A compare instruction sets each PE's flag from its own word. The arithmetic and load instructions that follow then act only on PEs whose flag is set, while the others hold their word for that step.

The host first writes the element words one at a time through an indexed write port, while the array is idle. It then pulses `start` with a program selector. When the program's last instruction has executed, the sequencer pulses `done`. The results are read back through an indexed, combinational read port. Program 0 performs the threshold-dependent scaling update: words above 100000 are multiplied by about 1.05, and all other words by about 1.10. The two branches use two complementary masked multiplies. Program 1 exercises the load, multiply and flag instructions on a different pattern.

Top module: `simd_mask_array`

## Requirements
- R1: After reset every element word reads 0, and `busy` and `done` are low.
- R2: While the array is idle, `wr_en` writes `wr_data` into the element selected by `wr_idx`. `rd_data` always shows the word of the element selected by `rd_idx`, with no clock delay.
- R3: A `start` sampled while idle launches the six-instruction program chosen by `prog_sel`, and `busy` is high while it runs. `done` rises right after the sixth rising edge that follows the edge which accepted `start`. It stays high for exactly one cycle, and `busy` is low whenever `done` is high.
- R4: The compare instruction writes every PE's flag, whatever its previous value. The flag becomes 1 exactly when the PE's word is greater than the operand, compared as unsigned numbers.
- R5: The masked multiply replaces each flagged PE's word with floor(word × operand / 65536) mod 2^32. The operand is an unsigned factor with 16 fractional bits.
- R6: During a masked multiply or masked load, a PE whose flag is clear keeps its word unchanged.
- R7: The invert instruction complements every flag. The set-all instruction sets every flag to 1.
- R8: The masked load writes the operand into the word of every flagged PE.
- R9: The no-operation instruction leaves every word and every flag unchanged.
- R10: Program 0 compares against 100000. It then multiplies the flagged PEs by 68813/65536, inverts the flags, multiplies the newly flagged PEs by 72090/65536, sets all flags, and finishes with a no-operation. The net result is that each word above 100000 is scaled once by 68813/65536, and every other word is scaled once by 72090/65536.
- R11: Program 1 compares against 1000, inverts the flags, loads 42, sets all flags, multiplies by 131072/65536, and finishes with a no-operation. The net result is that each word of at most 1000 ends as 84, and every other word ends doubled mod 2^32.
- R12: While `busy` is high, `wr_en` and `start` are ignored. No element word changes through the write port, and the running program neither restarts nor changes length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the selected program (only accepted while idle) |
| prog_sel | input | 1 | Program selector: 0 = threshold scaling, 1 = load/double pattern |
| wr_en | input | 1 | Element write strobe (only accepted while idle) |
| wr_idx | input | 3 | Element index for writes |
| wr_data | input | 32 | Element write data |
| rd_idx | input | 3 | Element index for readback |
| rd_data | output | 32 | Word of the indexed element |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle pulse after the last instruction has executed |

## Verification
A flag left in the wrong state makes no immediate difference at the ports. It shows up only after the next masked multiply or load, when that PE's word ends up scaled twice, not at all, or overwritten. That word then reads wrong from the cycle after `done`. A fault in the sequencer shows up as a `done` pulse that comes early, late or stretched, and the number of edges from `start` to `done` reveals it. A write that slips through while busy corrupts exactly one word, and the corruption is visible at readback as soon as the program ends.

// File: rtl/simd_mask_pkg.sv
package simd_mask_pkg;
  localparam int WORD_W    = 32;
  localparam int FRAC_W    = 16;
  localparam int STEPS     = 6;
  localparam int N_PROGS   = 2;
  localparam int ROM_DEPTH = STEPS * N_PROGS;
  localparam int PC_W      = $clog2(ROM_DEPTH);
  localparam int SEL_W     = $clog2(N_PROGS);
  localparam int CNT_W     = $clog2(STEPS);

  localparam logic [WORD_W-1:0] CUT_HI    = 32'd100000;
  localparam logic [WORD_W-1:0] GAIN_HI   = 32'd68813;
  localparam logic [WORD_W-1:0] GAIN_LO   = 32'd72090;
  localparam logic [WORD_W-1:0] CUT_SMALL = 32'd1000;
  localparam logic [WORD_W-1:0] FILL_VAL  = 32'd42;
  localparam logic [WORD_W-1:0] GAIN_X2   = 32'd131072;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_LOADI   = 3'd1,
    OP_CMPGT   = 3'd2,
    OP_MULMASK = 3'd3,
    OP_INVMASK = 3'd4,
    OP_SETALL  = 3'd5
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [WORD_W-1:0] arg;
  } instr_t;

  // Unsigned fixed-point scale, truncated to the word width.
  function automatic logic [WORD_W-1:0] q_scale(input logic [WORD_W-1:0] x,
                                                input logic [WORD_W-1:0] f);
    logic [2*WORD_W-1:0] prod;
    prod = {{WORD_W{1'b0}}, x} * {{WORD_W{1'b0}}, f};
    return prod[FRAC_W +: WORD_W];
  endfunction

  function automatic instr_t mk(input op_e op, input logic [WORD_W-1:0] arg);
    instr_t t;
    t.op  = op;
    t.arg = arg;
    return t;
  endfunction

  // Program ROM: two programs of STEPS words each.
  function automatic instr_t rom_word(input logic [PC_W-1:0] addr);
    instr_t t;
    case (int'(addr))
      0:       t = mk(OP_CMPGT,   CUT_HI);
      1:       t = mk(OP_MULMASK, GAIN_HI);
      2:       t = mk(OP_INVMASK, '0);
      3:       t = mk(OP_MULMASK, GAIN_LO);
      4:       t = mk(OP_SETALL,  '0);
      5:       t = mk(OP_NOP,     '0);
      6:       t = mk(OP_CMPGT,   CUT_SMALL);
      7:       t = mk(OP_INVMASK, '0);
      8:       t = mk(OP_LOADI,   FILL_VAL);
      9:       t = mk(OP_SETALL,  '0);
      10:      t = mk(OP_MULMASK, GAIN_X2);
      default: t = mk(OP_NOP,     '0);
    endcase
    return t;
  endfunction
endpackage

// File: rtl/simd_seq.sv
module simd_seq
  import simd_mask_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] prog_sel,
  output logic             busy,
  output logic             done,
  output logic             exec_valid,
  output instr_t           exec_instr
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  logic [CNT_W-1:0] step_q;
  logic [SEL_W-1:0] sel_q;
  logic [PC_W-1:0]  pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      step_q <= '0;
      sel_q  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          step_q <= '0;
          sel_q  <= prog_sel;
        end
      end else if (step_q == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign pc         = PC_W'(int'(sel_q) * STEPS + int'(step_q));
  assign exec_valid = busy;
  assign exec_instr = rom_word(pc);
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              exec_valid,
  input  instr_t            instr,
  output logic [WORD_W-1:0] word_q,
  output logic              flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      flag_q <= 1'b1;
    end else if (exec_valid) begin
      case (instr.op)
        OP_CMPGT:   flag_q <= (word_q > instr.arg);
        OP_MULMASK: if (flag_q) word_q <= q_scale(word_q, instr.arg);
        OP_LOADI:   if (flag_q) word_q <= instr.arg;
        OP_INVMASK: flag_q <= ~flag_q;
        OP_SETALL:  flag_q <= 1'b1;
        default:    ;
      endcase
    end else if (wr_en) begin
      word_q <= wr_data;
    end
  end
endmodule

// File: rtl/simd_mask_array.sv
module simd_mask_array
  import simd_mask_pkg::*;
#(
  parameter int N_PE = 8,
  localparam int IDX_W = $clog2(N_PE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  prog_sel,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              done
);
  logic                         exec_valid;
  instr_t                       exec_instr;
  op_e                          exec_op;
  logic [N_PE-1:0]              mask_vec;
  logic [N_PE-1:0][WORD_W-1:0]  pe_words;
  logic [N_PE-1:0]              pe_wr;

  simd_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .prog_sel   (prog_sel),
    .busy       (busy),
    .done       (done),
    .exec_valid (exec_valid),
    .exec_instr (exec_instr)
  );

  assign exec_op = exec_instr.op;

  for (genvar g = 0; g < N_PE; g++) begin : g_pe
    assign pe_wr[g] = wr_en && !busy && (wr_idx == IDX_W'(g));
    simd_pe pe_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (pe_wr[g]),
      .wr_data    (wr_data),
      .exec_valid (exec_valid),
      .instr      (exec_instr),
      .word_q     (pe_words[g]),
      .flag_q     (mask_vec[g])
    );
  end

  assign rd_data = pe_words[rd_idx];
endmodule

// File: rtl/simd_mask_array_chk.sv
module simd_mask_array_chk
  import simd_mask_pkg::*;
#(
  parameter int N_PE = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        busy,
  input logic                        done,
  input logic                        exec_valid,
  input op_e                         exec_op,
  input logic [N_PE-1:0]             mask_vec,
  input logic [N_PE-1:0][WORD_W-1:0] pe_words
);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  invert_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_op == OP_INVMASK) |=> (mask_vec == ~$past(mask_vec)));

  // R7
  setall_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_op == OP_SETALL) |=> (&mask_vec));

  // R9
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_op == OP_NOP) |=> ($stable(mask_vec) && $stable(pe_words)));

  // R12
  busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && (exec_op == OP_CMPGT || exec_op == OP_INVMASK || exec_op == OP_SETALL))
      |=> $stable(pe_words));

  for (genvar i = 0; i < N_PE; i++) begin : g_hold
    // R6
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && (exec_op == OP_MULMASK || exec_op == OP_LOADI) && !mask_vec[i])
        |=> $stable(pe_words[i]));
  end
endmodule

bind simd_mask_array simd_mask_array_chk #(.N_PE(N_PE)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .exec_valid (exec_valid),
  .exec_op    (exec_op),
  .mask_vec   (mask_vec),
  .pe_words   (pe_words)
);

// File: tb/simd_mask_array_tb_top.sv
module simd_mask_array_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [0:0]  prog_sel = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        busy, done;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  simd_mask_array dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .prog_sel(prog_sel),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy), .done(done)
  );

  localparam logic [31:0] VEC [16] = '{
    32'd0, 32'd1, 32'd1000, 32'd1001, 32'd99999, 32'd100000, 32'd100001, 32'd65536,
    32'd200000, 32'd5000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'd123456, 32'd42,
    32'd2000000000, 32'h80000000
  };

  // Expected results restated from R10 and R11.
  function automatic logic [31:0] want_p0(input logic [31:0] x);
    longint unsigned w;
    w = longint'(x);
    if (x > 32'd100000) w = (w * 64'd68813) / 64'd65536;
    else                w = (w * 64'd72090) / 64'd65536;
    return w[31:0];
  endfunction

  function automatic logic [31:0] want_p1(input logic [31:0] x);
    if (x <= 32'd1000) return 32'd84;
    return x + x;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_word(input int idx, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_word(input int idx, output logic [31:0] val);
    rd_idx = 3'(idx);
    #1;
    val = rd_data;
  endtask

  task automatic run_prog(input logic sel, input bit intrude);
    int  n;
    bit  seen;
    @(negedge clk);
    start = 1'b1; prog_sel = sel;
    @(negedge clk);
    start = 1'b0;
    check("R3 busy after start", 32'(busy), 32'd1);
    n = 0; seen = 1'b0;
    for (int k = 1; k <= 20 && !seen; k++) begin
      if (intrude && k == 2) begin
        wr_en = 1'b1; wr_idx = 3'd3; wr_data = 32'hDEADBEEF; start = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; start = 1'b0;
      if (done) begin seen = 1'b1; n = k; end
    end
    check(intrude ? "R12 R3 done edge count" : "R3 done edge count", 32'(n), 32'd6);
    check("R3 busy low at done", 32'(busy), 32'd0);
    @(negedge clk);
    check("R3 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      read_word(i, v);
      check("R1 reset word", v, 32'd0);
    end
    check("R1 busy reset", 32'(busy), 32'd0);
    check("R1 done reset", 32'(done), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: two batches of 8 words, each through both programs.
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 8; i++) write_word(i, VEC[b*8+i]);
      for (int i = 0; i < 8; i++) begin
        read_word(i, v);
        check("R2 readback", v, VEC[b*8+i]);
      end
      run_prog(1'b0, 1'b0);
      for (int i = 0; i < 8; i++) begin
        read_word(i, v);
        check("R10 R4 R5 R6 R7 program 0", v, want_p0(VEC[b*8+i]));
      end
      for (int i = 0; i < 8; i++) write_word(i, VEC[b*8+i]);
      run_prog(1'b1, 1'b0);
      for (int i = 0; i < 8; i++) begin
        read_word(i, v);
        check("R11 R8 R9 R5 program 1", v, want_p1(VEC[b*8+i]));
      end
    end

    // R12: write and start while busy are ignored.
    for (int i = 0; i < 8; i++) write_word(i, 32'd500 + 32'(i) * 32'd300000);
    run_prog(1'b0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      read_word(i, v);
      check("R12 busy write ignored", v, want_p0(32'd500 + 32'(i) * 32'd300000));
    end
    check("R12 no restart", 32'(busy), 32'd0);

    // R6 corner: exact threshold value stays on the low branch only once.
    write_word(5, 32'd100000);
    run_prog(1'b0, 1'b0);
    read_word(5, v);
    check("R4 R6 threshold equal", v, 32'd110000);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule